// File: doc/BRIEF.md
# Micro-Word Transport Packet Reassembler

The block receives a single stream of 32-bit micro-words in which up to four transport-stream channels are interleaved. Each word carries a channel code, a three-bit sequence count, a packet-start flag and an upstream-overflow flag in its top byte. The low 24 bits carry up to three payload bytes. Sixty-three consecutive words of one channel rebuild one 188-byte transport packet. The last of these words supplies only two bytes.

For every channel the block emits the rebuilt bytes on a byte-wide valid/ready stream. First-byte and last-byte markers travel with the data. Each channel holds at most one word in flight, and the input stalls while the addressed channel is still draining its previous word. A word that fails the sequence check, or that carries the overflow flag, produces a one-cycle pulse tagged with the channel index. It also sets a per-channel sticky status bit, which the consumer clears through a per-channel clear input.

A word with the start flag restarts the packet alignment for its channel. A packet that is cut short by such a restart is simply left without an end marker.

Top module: `tswr_reasm`

## Requirements
- R1: The channel code sits in word bits 31:29. A code of 1 to NUM_CH addresses channel code-1. Any other code (0, or above NUM_CH) is accepted at once with in_ready high, and it produces no output byte, no event and no state change.
- R2: A kept word with bit 25 set restarts its channel's alignment. Its first payload byte is emitted with out_sop high.
- R3: A word without bit 25 that arrives while its channel's word counter is zero is dropped. It emits no bytes, raises no event and leaves the sequence reference unchanged.
- R4: A kept word with bit 24 set raises ovf_pulse for exactly one cycle, in the cycle after acceptance, with ovf_chan set to the channel index. It also sets sticky_ovf for that channel.
- R5: Bits 28:26 of a kept word are compared with the stored reference plus one, modulo 8. On a mismatch, loss_pulse is raised for one cycle in the cycle after acceptance, with loss_chan tagged, and sticky_loss is set. In every case the received value becomes the new reference.
- R6: After reset a channel has no sequence reference, so its first kept word never raises a loss event.
- R7: Payload bytes of a word leave in the order bits 23:16, then 15:8, then 7:0.
- R8: The 63rd word of a packet emits only its bits 23:16 and 15:8. The second of these bytes is byte 187 and carries out_eop. The word counter then returns to zero.
- R9: While out_valid is high and out_ready is low, a channel holds out_valid, out_data and its markers unchanged. A word addressed to a channel that still holds bytes sees in_ready low.
- R10: Raising status_clr for a channel clears both of its sticky bits. An event for that channel in the same cycle takes precedence over the clear.
- R11: After reset, in_ready is high, every out_valid is low, both pulses are low and all sticky bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Micro-word offered |
| in_ready | output | 1 | Micro-word taken this cycle when in_valid is high |
| in_word | input | 32 | Micro-word: code, sequence, start, overflow, payload |
| out_valid | output | NUM_CH | Per-channel byte valid |
| out_ready | input | NUM_CH | Per-channel byte accept |
| out_data | output | 8*NUM_CH | Per-channel byte, channel i in bits 8i+7:8i |
| out_sop | output | NUM_CH | Byte is the first of a packet |
| out_eop | output | NUM_CH | Byte is byte 187 of a packet |
| ovf_pulse | output | 1 | One-cycle overflow event |
| ovf_chan | output | CHW | Channel of the overflow event |
| loss_pulse | output | 1 | One-cycle sequence-gap event |
| loss_chan | output | CHW | Channel of the sequence-gap event |
| sticky_ovf | output | NUM_CH | Latched overflow per channel |
| sticky_loss | output | NUM_CH | Latched sequence gap per channel |
| status_clr | input | NUM_CH | Clears a channel's sticky bits |

## Verification
The assertions check on every cycle the following properties:
- Stalled byte outputs stay frozen.
- Invalid channel codes never stall the input.
- Markers only appear on valid bytes, and both markers never mark the same byte.
- Event pulses always follow an accepted word with the matching flag, and they agree with the sticky bits.
- Sticky bits survive until cleared.

Only the bench scenarios can show the following behaviour:
- Byte order and packet alignment across interleaved channels.
- Dropping of orphan words before a start.
- The two-byte final word.
- A restart in the middle of a packet.
- The exact count and channel of the sequence-gap and overflow events, including the unchecked first word.

// File: rtl/tswr_pkg.sv
package tswr_pkg;

   localparam int CODE_W = 3;
   localparam int SEQ_W  = 3;
   localparam int PAY_W  = 24;

   // Field positions are fixed by the word format: code 31:29, seq 28:26,
   // start 25, overflow 24, payload 23:0.
   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic [SEQ_W-1:0]  seq;
      logic              start;
      logic              ovf;
      logic [PAY_W-1:0]  payload;
   } uword_t;

   function automatic int chan_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/tswr_decode.sv
module tswr_decode
   import tswr_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic [31:0]       word,
   output logic [NUM_CH-1:0] sel,
   output logic              hit,
   output logic              start,
   output logic              ovf,
   output logic [SEQ_W-1:0]  seq,
   output logic [PAY_W-1:0]  payload
);

   uword_t wd;
   assign wd = uword_t'(word);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      assign sel[i] = (wd.code == CODE_W'(i + 1));
   end

   assign hit     = |sel;
   assign start   = wd.start;
   assign ovf     = wd.ovf;
   assign seq     = wd.seq;
   assign payload = wd.payload;

endmodule

// File: rtl/tswr_chan.sv
module tswr_chan
   import tswr_pkg::*;
#(
   parameter int WORDS_PER_PKT = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             w_start,
   input  logic             w_ovf,
   input  logic [SEQ_W-1:0] w_seq,
   input  logic [PAY_W-1:0] w_payload,
   output logic             can_take,
   output logic             ovf_ev,
   output logic             loss_ev,
   output logic             o_valid,
   input  logic             o_ready,
   output logic [7:0]       o_data,
   output logic             o_sop,
   output logic             o_eop
);

   localparam int WCW = $clog2(WORDS_PER_PKT);
   localparam logic [WCW-1:0] LAST_W = WCW'(WORDS_PER_PKT - 1);

   logic [WCW-1:0]   wcnt_q, widx_q, cur;
   logic [1:0]       remain_q, kidx_q;
   logic [PAY_W-1:0] sh_q;
   logic [SEQ_W-1:0] ref_q;
   logic             ref_v_q;
   logic             kept, last, orphan;

   assign cur    = w_start ? '0 : wcnt_q;
   assign last   = (cur == LAST_W);
   assign orphan = !w_start && (wcnt_q == '0);
   assign kept   = take && !orphan;

   // A word that will be dropped never needs the serializer.
   assign can_take = orphan || (remain_q == 2'd0);

   assign ovf_ev  = kept && w_ovf;
   assign loss_ev = kept && ref_v_q && (w_seq != SEQ_W'(ref_q + SEQ_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt_q   <= '0;
         widx_q   <= '0;
         remain_q <= 2'd0;
         kidx_q   <= 2'd0;
         sh_q     <= '0;
         ref_q    <= '0;
         ref_v_q  <= 1'b0;
      end else if (kept) begin
         wcnt_q   <= last ? '0 : WCW'(cur + WCW'(1));
         widx_q   <= cur;
         remain_q <= last ? 2'd2 : 2'd3;
         kidx_q   <= 2'd0;
         sh_q     <= w_payload;
         ref_q    <= w_seq;
         ref_v_q  <= 1'b1;
      end else if (o_valid && o_ready) begin
         remain_q <= remain_q - 2'd1;
         kidx_q   <= kidx_q + 2'd1;
      end
   end

   always_comb begin
      unique case (kidx_q)
         2'd0:    o_data = sh_q[23:16];
         2'd1:    o_data = sh_q[15:8];
         default: o_data = sh_q[7:0];
      endcase
   end

   assign o_valid = (remain_q != 2'd0);
   assign o_sop   = o_valid && (widx_q == '0) && (kidx_q == 2'd0);
   assign o_eop   = o_valid && (widx_q == LAST_W) && (kidx_q == 2'd1);

endmodule

// File: rtl/tswr_events.sv
module tswr_events #(
   parameter int NUM_CH = 4,
   parameter int CHW    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ovf_ev,
   input  logic [NUM_CH-1:0] loss_ev,
   input  logic [NUM_CH-1:0] clr,
   output logic              ovf_pulse,
   output logic [CHW-1:0]    ovf_chan,
   output logic              loss_pulse,
   output logic [CHW-1:0]    loss_chan,
   output logic [NUM_CH-1:0] sticky_ovf,
   output logic [NUM_CH-1:0] sticky_loss
);

   logic [CHW-1:0] ovf_idx, loss_idx;

   // At most one word is accepted per cycle, so at most one bit is set.
   always_comb begin
      ovf_idx  = '0;
      loss_idx = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ovf_ev[i])  ovf_idx  = CHW'(i);
         if (loss_ev[i]) loss_idx = CHW'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_pulse  <= 1'b0;
         ovf_chan   <= '0;
         loss_pulse <= 1'b0;
         loss_chan  <= '0;
      end else begin
         ovf_pulse  <= |ovf_ev;
         ovf_chan   <= ovf_idx;
         loss_pulse <= |loss_ev;
         loss_chan  <= loss_idx;
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sticky
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sticky_ovf[i]  <= 1'b0;
            sticky_loss[i] <= 1'b0;
         end else begin
            sticky_ovf[i]  <= ovf_ev[i]  || (sticky_ovf[i]  && !clr[i]);
            sticky_loss[i] <= loss_ev[i] || (sticky_loss[i] && !clr[i]);
         end
      end
   end

endmodule

// File: rtl/tswr_reasm.sv
module tswr_reasm
   import tswr_pkg::*;
#(
   parameter int NUM_CH        = 4,
   parameter int WORDS_PER_PKT = 63,
   parameter int CHW           = tswr_pkg::chan_idx_w(NUM_CH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [31:0]         in_word,
   output logic [NUM_CH-1:0]   out_valid,
   input  logic [NUM_CH-1:0]   out_ready,
   output logic [8*NUM_CH-1:0] out_data,
   output logic [NUM_CH-1:0]   out_sop,
   output logic [NUM_CH-1:0]   out_eop,
   output logic                ovf_pulse,
   output logic [CHW-1:0]      ovf_chan,
   output logic                loss_pulse,
   output logic [CHW-1:0]      loss_chan,
   output logic [NUM_CH-1:0]   sticky_ovf,
   output logic [NUM_CH-1:0]   sticky_loss,
   input  logic [NUM_CH-1:0]   status_clr
);

   localparam int PKT_BYTES = 3 * WORDS_PER_PKT - 1;

   if (NUM_CH < 1 || NUM_CH > 7) begin : g_bad_nch
      $error("NUM_CH must lie in 1..7 to fit the 3-bit channel code");
   end
   if (WORDS_PER_PKT < 2) begin : g_bad_wpp
      $error("WORDS_PER_PKT must be at least 2");
   end
   if (PKT_BYTES < 5) begin : g_bad_len
      $error("packet length too short");
   end

   logic [NUM_CH-1:0] sel, can_take, take, ovf_ev, loss_ev;
   logic              hit, w_start, w_ovf;
   logic [SEQ_W-1:0]  w_seq;
   logic [PAY_W-1:0]  w_payload;

   tswr_decode #(.NUM_CH(NUM_CH)) u_dec (
      .word    (in_word),
      .sel     (sel),
      .hit     (hit),
      .start   (w_start),
      .ovf     (w_ovf),
      .seq     (w_seq),
      .payload (w_payload)
   );

   assign in_ready = !hit || |(sel & can_take);
   assign take     = sel & {NUM_CH{in_valid && in_ready}};

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tswr_chan #(.WORDS_PER_PKT(WORDS_PER_PKT)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .take      (take[i]),
         .w_start   (w_start),
         .w_ovf     (w_ovf),
         .w_seq     (w_seq),
         .w_payload (w_payload),
         .can_take  (can_take[i]),
         .ovf_ev    (ovf_ev[i]),
         .loss_ev   (loss_ev[i]),
         .o_valid   (out_valid[i]),
         .o_ready   (out_ready[i]),
         .o_data    (out_data[8*i +: 8]),
         .o_sop     (out_sop[i]),
         .o_eop     (out_eop[i])
      );
   end

   tswr_events #(.NUM_CH(NUM_CH), .CHW(CHW)) u_evt (
      .clk         (clk),
      .rst_n       (rst_n),
      .ovf_ev      (ovf_ev),
      .loss_ev     (loss_ev),
      .clr         (status_clr),
      .ovf_pulse   (ovf_pulse),
      .ovf_chan    (ovf_chan),
      .loss_pulse  (loss_pulse),
      .loss_chan   (loss_chan),
      .sticky_ovf  (sticky_ovf),
      .sticky_loss (sticky_loss)
   );

endmodule

// File: rtl/tswr_reasm_chk.sv
module tswr_reasm_chk #(
   parameter int NUM_CH = 4,
   parameter int CHW    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic [2:0]          in_code,
   input logic                in_ovf_bit,
   input logic [NUM_CH-1:0]   out_valid,
   input logic [NUM_CH-1:0]   out_ready,
   input logic [8*NUM_CH-1:0] out_data,
   input logic [NUM_CH-1:0]   out_sop,
   input logic [NUM_CH-1:0]   out_eop,
   input logic                ovf_pulse,
   input logic [CHW-1:0]      ovf_chan,
   input logic                loss_pulse,
   input logic [CHW-1:0]      loss_chan,
   input logic [NUM_CH-1:0]   sticky_ovf,
   input logic [NUM_CH-1:0]   sticky_loss,
   input logic [NUM_CH-1:0]   status_clr
);

   // R1
   bad_code_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_code == 3'd0 || in_code > 3'(NUM_CH)) |-> in_ready);

   // R4
   ovf_after_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> $past(in_valid && in_ready && in_ovf_bit));

   // R4
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> sticky_ovf[ovf_chan]);

   // R5
   loss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loss_pulse |-> sticky_loss[loss_chan]);

   // R5
   loss_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loss_pulse |-> $past(in_valid && in_ready));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      // R9
      stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[i] && !out_ready[i]) |=> (out_valid[i]
            && $stable(out_data[8*i +: 8]) && $stable(out_sop[i])
            && $stable(out_eop[i])));

      // R8
      marker_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_sop[i] || out_eop[i]) |-> (out_valid[i] && !(out_sop[i] && out_eop[i])));

      // R10
      sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sticky_ovf[i] && !status_clr[i]) |=> sticky_ovf[i]);

      // R10
      sticky_loss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sticky_loss[i] && !status_clr[i]) |=> sticky_loss[i]);
   end

endmodule

bind tswr_reasm tswr_reasm_chk #(.NUM_CH(NUM_CH), .CHW(CHW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .in_code     (in_word[31:29]),
   .in_ovf_bit  (in_word[24]),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_data    (out_data),
   .out_sop     (out_sop),
   .out_eop     (out_eop),
   .ovf_pulse   (ovf_pulse),
   .ovf_chan    (ovf_chan),
   .loss_pulse  (loss_pulse),
   .loss_chan   (loss_chan),
   .sticky_ovf  (sticky_ovf),
   .sticky_loss (sticky_loss),
   .status_clr  (status_clr)
);

// File: tb/tswr_reasm_tb.sv
module tswr_reasm_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int WPP = 63;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [31:0]       in_word = '0;
   logic [NCH-1:0]    out_valid, out_ready, out_sop, out_eop;
   logic [8*NCH-1:0]  out_data;
   logic              ovf_pulse, loss_pulse;
   logic [1:0]        ovf_chan, loss_chan;
   logic [NCH-1:0]    sticky_ovf, sticky_loss;
   logic [NCH-1:0]    status_clr = '0;

   logic [NCH-1:0]    rdy_ctl = '1;
   logic              tog_bit = 1'b1;
   bit                tog_en = 1'b0;
   int                tog_cnt = 0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int cyc = 0;

   // reference model state
   logic [9:0] expq [NCH][$];
   int  m_wc   [NCH];
   int  m_ref  [NCH];
   bit  m_refv [NCH];
   int  exp_ovf [NCH];
   int  exp_loss[NCH];
   int  obs_ovf [NCH];
   int  obs_loss[NCH];
   int  obs_bytes[NCH];
   int  scnt [NCH];

   assign out_ready = rdy_ctl & {{(NCH-1){1'b1}}, tog_bit};

   tswr_reasm #(.NUM_CH(NCH), .WORDS_PER_PKT(WPP)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
      .ovf_pulse(ovf_pulse), .ovf_chan(ovf_chan), .loss_pulse(loss_pulse),
      .loss_chan(loss_chan), .sticky_ovf(sticky_ovf), .sticky_loss(sticky_loss),
      .status_clr(status_clr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pbyte(input int c, input int p, input int j);
      return 8'(c * 61 + p * 17 + j * 3 + 5);
   endfunction

   function automatic logic [31:0] mkword(input int code, input int sq, input bit st,
                                         input bit ov, input logic [23:0] pay);
      return {3'(code), 3'(sq), st, ov, pay};
   endfunction

   // Model of R1..R8 applied to an accepted word.
   task automatic model(input logic [31:0] w);
      int c;
      int sq;
      c = int'(w[31:29]) - 1;
      if (c < 0 || c >= NCH) return;
      if (!w[25] && m_wc[c] == 0) return;
      if (w[25]) m_wc[c] = 0;
      if (w[24]) exp_ovf[c]++;
      sq = int'(w[28:26]);
      if (m_refv[c] && sq != ((m_ref[c] + 1) % 8)) exp_loss[c]++;
      m_ref[c] = sq;
      m_refv[c] = 1'b1;
      expq[c].push_back({m_wc[c] == 0, 1'b0, w[23:16]});
      expq[c].push_back({1'b0, m_wc[c] == WPP - 1, w[15:8]});
      if (m_wc[c] != WPP - 1) expq[c].push_back({2'b00, w[7:0]});
      m_wc[c] = (m_wc[c] == WPP - 1) ? 0 : m_wc[c] + 1;
   endtask

   task automatic finish_accept(input logic [31:0] w);
      while (!in_ready) begin
         @(negedge clk); #1;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      model(w);
   endtask

   task automatic send(input logic [31:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_word = w;
      #1;
      finish_accept(w);
   endtask

   task automatic send_pkt_word(input int c, input int p, input int k,
                                input bit st, input bit ov);
      logic [7:0] b2;
      b2 = (k == WPP - 1) ? 8'hEE : pbyte(c, p, 3 * k + 2);
      send(mkword(c + 1, scnt[c], st, ov, {pbyte(c, p, 3 * k), pbyte(c, p, 3 * k + 1), b2}));
      scnt[c] = (scnt[c] + 1) % 8;
   endtask

   // output collector and event counter, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            if (out_valid[c] && out_ready[c]) begin
               logic [9:0] e;
               logic [9:0] a;
               obs_bytes[c]++;
               a = {out_sop[c], out_eop[c], out_data[8*c +: 8]};
               if (expq[c].size() == 0) begin
                  chk(1'b0, "R1 unexpected byte", 32'(a), 32'h0);
               end else begin
                  e = expq[c].pop_front();
                  chk(a == e, e[9] ? "R2 sop byte" : (e[8] ? "R8 eop byte" : "R7 byte order"),
                      32'(a), 32'(e));
               end
            end
         end
         if (ovf_pulse)  obs_ovf[ovf_chan]++;
         if (loss_pulse) obs_loss[loss_chan]++;
      end
   end

   always @(posedge clk) begin
      #2;
      tog_cnt++;
      tog_bit = tog_en ? (tog_cnt % 3 != 0) : 1'b1;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] hold;
      int total;
      for (int c = 0; c < NCH; c++) begin
         m_wc[c] = 0; m_ref[c] = 0; m_refv[c] = 0;
         exp_ovf[c] = 0; exp_loss[c] = 0; obs_ovf[c] = 0; obs_loss[c] = 0;
         obs_bytes[c] = 0; scnt[c] = (2 * c + 3) % 8;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(in_ready == 1'b1, "R11 in_ready", 32'(in_ready), 32'h1);
      chk(out_valid == '0, "R11 out_valid", 32'(out_valid), 32'h0);
      chk(!ovf_pulse && !loss_pulse, "R11 pulses", {30'h0, ovf_pulse, loss_pulse}, 32'h0);
      chk(sticky_ovf == '0 && sticky_loss == '0, "R11 sticky",
          32'({sticky_ovf, sticky_loss}), 32'h0);

      // R1: invalid codes are taken without stall and do nothing
      for (int code = 0; code < 8; code++) begin
         if (code == 0 || code > NCH) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_word = mkword(code, 1, 1'b1, 1'b1, 24'h123456);
            #1;
            chk(in_ready == 1'b1, "R1 no stall on invalid code", 32'(in_ready), 32'h1);
            finish_accept(in_word);
         end
      end
      repeat (4) @(negedge clk);
      chk(obs_bytes[0] + obs_bytes[1] + obs_bytes[2] + obs_bytes[3] == 0,
          "R1 no output for invalid code", 32'(obs_bytes[0]), 32'h0);
      chk(sticky_ovf == '0, "R1 no event for invalid code", 32'(sticky_ovf), 32'h0);

      // R3: orphan words on channel 2, with overflow flag and broken sequence
      for (int k = 0; k < 5; k++)
         send(mkword(3, (k * 3) % 8, 1'b0, 1'b1, 24'hABCDEF));
      repeat (6) @(negedge clk);
      chk(obs_bytes[2] == 0, "R3 orphan bytes", 32'(obs_bytes[2]), 32'h0);
      chk(obs_ovf[2] == 0 && obs_loss[2] == 0, "R3 orphan events",
          32'(obs_ovf[2] + obs_loss[2]), 32'h0);
      chk(sticky_ovf == '0 && sticky_loss == '0, "R3 orphan sticky",
          32'({sticky_ovf, sticky_loss}), 32'h0);

      // Interleaved packets on all channels, channel 0 throttled
      tog_en = 1'b1;
      for (int p = 0; p < 3; p++) begin
         for (int k = 0; k < WPP; k++) begin
            for (int c = 0; c < NCH; c++) begin
               if (c == 2 && p == 1 && k == 30) scnt[c] = (scnt[c] + 1) % 8;
               send_pkt_word(c, p, k, k == 0,
                             (c == 1 && p == 1 && k == 10) || (c == 3 && p == 2 && k == WPP - 1));
            end
            if (p == 0 && k == 0) begin
               repeat (2) @(negedge clk);
               total = obs_loss[0] + obs_loss[1] + obs_loss[2] + obs_loss[3];
               chk(total == 0, "R6 first word unchecked", 32'(total), 32'h0);
            end
         end
      end
      // restart in the middle of a packet on channel 3
      for (int k = 0; k < 10; k++) send_pkt_word(3, 3, k, k == 0, 1'b0);
      for (int k = 0; k < WPP; k++) send_pkt_word(3, 4, k, k == 0, 1'b0);
      tog_en = 1'b0;
      repeat (60) @(negedge clk);

      // R9: stall behaviour on channel 1
      @(posedge clk); #2;
      rdy_ctl[1] = 1'b0;
      send(mkword(2, scnt[1], 1'b1, 1'b0, {pbyte(1, 5, 0), pbyte(1, 5, 1), pbyte(1, 5, 2)}));
      scnt[1] = (scnt[1] + 1) % 8;
      @(negedge clk);
      hold = out_data[15:8];
      chk(out_valid[1] == 1'b1, "R9 byte waiting", 32'(out_valid[1]), 32'h1);
      chk(hold == pbyte(1, 5, 0), "R9 held byte value", 32'(hold), 32'(pbyte(1, 5, 0)));
      in_valid = 1'b1;
      in_word = mkword(2, scnt[1], 1'b0, 1'b0, {pbyte(1, 5, 3), pbyte(1, 5, 4), pbyte(1, 5, 5)});
      scnt[1] = (scnt[1] + 1) % 8;
      #1;
      chk(in_ready == 1'b0, "R9 input stalls on busy channel", 32'(in_ready), 32'h0);
      repeat (3) @(negedge clk);
      #1;
      chk(out_valid[1] && out_data[15:8] == hold && !in_ready, "R9 hold while stalled",
          32'(out_data[15:8]), 32'(hold));
      @(posedge clk); #2;
      rdy_ctl[1] = 1'b1;
      @(negedge clk); #1;
      finish_accept(in_word);

      // drain and compare
      repeat (40) @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
         chk(expq[c].size() == 0, "R2 all expected bytes seen", 32'(expq[c].size()), 32'h0);
         chk(obs_ovf[c] == exp_ovf[c], "R4 overflow events per channel",
             32'(obs_ovf[c]), 32'(exp_ovf[c]));
         chk(obs_loss[c] == exp_loss[c], "R5 loss events per channel",
             32'(obs_loss[c]), 32'(exp_loss[c]));
         chk(sticky_ovf[c] == (exp_ovf[c] > 0), "R4 sticky overflow",
             32'(sticky_ovf[c]), 32'(exp_ovf[c] > 0));
         chk(sticky_loss[c] == (exp_loss[c] > 0), "R5 sticky loss",
             32'(sticky_loss[c]), 32'(exp_loss[c] > 0));
      end
      chk(exp_loss[2] == 1 && exp_ovf[1] == 1 && exp_ovf[3] == 1, "R5 scenario coverage",
          32'(exp_loss[2]), 32'h1);

      // R10 clear
      @(posedge clk); #2;
      status_clr = '1;
      @(posedge clk); #2;
      status_clr = '0;
      @(negedge clk);
      chk(sticky_ovf == '0 && sticky_loss == '0, "R10 sticky cleared",
          32'({sticky_ovf, sticky_loss}), 32'h0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule